// File: doc/BRIEF.md
# Prioritized Interrupt Sorter with Re-arm Handshake

This block decides which interrupt line is presented to the processor. It drives two parent outputs: a normal interrupt and a fast interrupt. The enclosing controller supplies, for every line, a pending bit, a mask bit, a route bit that assigns the line to the fast class, and a priority value. Lines are grouped in banks of 32, and up to four banks are supported. For each class the block scans all lines in one cycle, finds the winner and latches its number into a per-class code register.

Each class has an arm flag. A winning code is captured only on an evaluation trigger and only while the flag is set. Capturing a code clears the flag and raises the parent output. Software finishes servicing an interrupt by issuing a re-arm command for that class. The command lowers the output, sets the flag again and starts a new evaluation in the same cycle. The controller asserts the evaluation triggers itself: a pulse when pending bits become set, and a pulse when the mask is written.

Top module: `intc_prio_sorter`

## Requirements
- R1: A line is a candidate for the normal class only when its pending bit is 1, its mask bit is 0 and its route bit is 0.
- R2: A line is a candidate for the fast class only when its pending bit is 1, its mask bit is 0 and its route bit is 1.
- R3: Among candidates, the line with the numerically smallest priority value wins, and 0 is the most urgent value.
- R4: When several candidates share the best priority, the one with the largest line number wins, including across banks.
- R5: The code reported for a line is 32 times its bank index plus its bit position. This equals its index in the flat vectors, where bit i of each vector and field i of the priority bus (bits i*PRIO_W and up) belong to line i.
- R6: On a clock edge where a trigger (pend_set_i, mask_wr_i, or the class's own re-arm) is high, the class's flag is set, a candidate exists and glob_en_i is 1, the block latches the winner code, clears the flag and drives the parent output high after that edge. While the flag is clear, later triggers change neither the code nor the output.
- R7: A re-arm command for a class sets its flag and re-evaluates in the same edge. If no code is captured, the output is low after the edge. If a candidate exists and glob_en_i is 1, the new winner's code is latched and the output stays high.
- R8: When a trigger finds no candidate, or glob_en_i is 0, the latched code keeps its value.
- R9: After reset both codes are 0, both outputs are low and both flags are set.
- R10: A candidate that appears with no trigger high causes no capture and leaves the outputs unchanged.
- R11: The two classes are independent: a re-arm of one class leaves the other class's output and code unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pending_i | input | NUM_BANKS*32 | Pending bit per line |
| mask_i | input | NUM_BANKS*32 | Mask bit per line, 1 blocks the line |
| route_fiq_i | input | NUM_BANKS*32 | 1 routes the line to the fast class |
| prio_i | input | NUM_BANKS*32*PRIO_W | Priority field per line, line i at bits i*PRIO_W and up |
| glob_en_i | input | 1 | Global enable for capturing codes |
| pend_set_i | input | 1 | Trigger pulse: pending bits were set |
| mask_wr_i | input | 1 | Trigger pulse: mask was written |
| rearm_irq_i | input | 1 | Re-arm command for the normal class |
| rearm_fiq_i | input | 1 | Re-arm command for the fast class |
| irq_o | output | 1 | Normal parent interrupt |
| fiq_o | output | 1 | Fast parent interrupt |
| irq_code_o | output | CODE_W | Latched winner code, normal class |
| fiq_code_o | output | CODE_W | Latched winner code, fast class |

## Verification
The bench sets up priority ties between lines in different banks. A scan that keeps the first match instead of the last would report the lower line number. It raises a new, more urgent line while a code is already latched. A design that ignores the arm flag would replace the code before the re-arm command. It offers candidates with the enable off, with no trigger, and with the line masked or routed to the other class. Each of these must leave the outputs untouched, and a missing qualifier would show up as a spurious capture. It also re-arms with nothing pending. A design that clears the code at that point, or leaves the output high, is caught.

// File: rtl/sorter_pkg.sv
package sorter_pkg;
  localparam int unsigned LINES_PER_BANK = 32;

  typedef enum logic {
    CLS_IRQ = 1'b0,
    CLS_FIQ = 1'b1
  } sort_class_e;

  localparam int unsigned NUM_CLASSES = 2;
endpackage

// File: rtl/sorter_cand.sv
module sorter_cand #(
  parameter int unsigned NUM_LINES = 128,
  parameter bit          IS_FIQ    = 1'b0
) (
  input  logic [NUM_LINES-1:0] pending_i,
  input  logic [NUM_LINES-1:0] mask_i,
  input  logic [NUM_LINES-1:0] route_fiq_i,
  output logic [NUM_LINES-1:0] cand_o
);
  localparam int unsigned NB = NUM_LINES / sorter_pkg::LINES_PER_BANK;
  localparam int unsigned LB = sorter_pkg::LINES_PER_BANK;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic [LB-1:0] route_match;
    if (IS_FIQ) begin : g_fast
      assign route_match = route_fiq_i[b*LB +: LB];
    end else begin : g_norm
      assign route_match = ~route_fiq_i[b*LB +: LB];
    end
    assign cand_o[b*LB +: LB] = pending_i[b*LB +: LB] & ~mask_i[b*LB +: LB] & route_match;
  end
endmodule

// File: rtl/sorter_scan.sv
module sorter_scan #(
  parameter int unsigned NUM_LINES = 128,
  parameter int unsigned PRIO_W    = 5,
  parameter int unsigned CODE_W    = $clog2(NUM_LINES)
) (
  input  logic [NUM_LINES-1:0]        cand_i,
  input  logic [NUM_LINES*PRIO_W-1:0] prio_i,
  output logic                        any_o,
  output logic [CODE_W-1:0]           win_o
);
  // Ascending scan with "<=" keeps the last of equal priorities,
  // so ties resolve to the largest line number.
  always_comb begin
    logic [PRIO_W-1:0] best;
    best  = '1;
    any_o = 1'b0;
    win_o = '0;
    for (int unsigned i = 0; i < NUM_LINES; i++) begin
      if (cand_i[i] && (prio_i[i*PRIO_W +: PRIO_W] <= best)) begin
        best  = prio_i[i*PRIO_W +: PRIO_W];
        win_o = CODE_W'(i);
        any_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/sorter_class.sv
module sorter_class #(
  parameter int unsigned CODE_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_i,
  input  logic              rearm_i,
  input  logic              glob_en_i,
  input  logic              any_i,
  input  logic [CODE_W-1:0] win_i,
  output logic              out_o,
  output logic [CODE_W-1:0] code_o,
  output logic              fire_o
);
  logic armed_q;
  logic eval_w;
  logic armed_eff;

  assign eval_w    = trig_i | rearm_i;
  assign armed_eff = rearm_i | armed_q;
  assign fire_o    = eval_w & armed_eff & any_i & glob_en_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b1;
      out_o   <= 1'b0;
      code_o  <= '0;
    end else if (fire_o) begin
      armed_q <= 1'b0;
      out_o   <= 1'b1;
      code_o  <= win_i;
    end else if (rearm_i) begin
      armed_q <= 1'b1;
      out_o   <= 1'b0;
    end
  end
endmodule

// File: rtl/intc_prio_sorter.sv
module intc_prio_sorter #(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned PRIO_W    = 5,
  localparam int unsigned NUM_LINES = NUM_BANKS * sorter_pkg::LINES_PER_BANK,
  localparam int unsigned CODE_W    = $clog2(NUM_LINES)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_LINES-1:0]        pending_i,
  input  logic [NUM_LINES-1:0]        mask_i,
  input  logic [NUM_LINES-1:0]        route_fiq_i,
  input  logic [NUM_LINES*PRIO_W-1:0] prio_i,
  input  logic                        glob_en_i,
  input  logic                        pend_set_i,
  input  logic                        mask_wr_i,
  input  logic                        rearm_irq_i,
  input  logic                        rearm_fiq_i,
  output logic                        irq_o,
  output logic                        fiq_o,
  output logic [CODE_W-1:0]           irq_code_o,
  output logic [CODE_W-1:0]           fiq_code_o
);
  import sorter_pkg::*;

  logic                   trig_common;
  logic [NUM_CLASSES-1:0] cls_rearm;
  logic [NUM_CLASSES-1:0] cls_out;
  logic [NUM_CLASSES-1:0] cls_fire;
  logic [NUM_CLASSES-1:0] cls_any;
  logic [CODE_W-1:0]      cls_code [NUM_CLASSES];
  logic [CODE_W-1:0]      cls_win  [NUM_CLASSES];

  assign trig_common        = pend_set_i | mask_wr_i;
  assign cls_rearm[CLS_IRQ] = rearm_irq_i;
  assign cls_rearm[CLS_FIQ] = rearm_fiq_i;

  for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_cls
    logic [NUM_LINES-1:0] cand;

    sorter_cand #(
      .NUM_LINES (NUM_LINES),
      .IS_FIQ    (c == int'(CLS_FIQ))
    ) u_cand (
      .pending_i   (pending_i),
      .mask_i      (mask_i),
      .route_fiq_i (route_fiq_i),
      .cand_o      (cand)
    );

    sorter_scan #(
      .NUM_LINES (NUM_LINES),
      .PRIO_W    (PRIO_W),
      .CODE_W    (CODE_W)
    ) u_scan (
      .cand_i (cand),
      .prio_i (prio_i),
      .any_o  (cls_any[c]),
      .win_o  (cls_win[c])
    );

    sorter_class #(
      .CODE_W (CODE_W)
    ) u_class (
      .clk       (clk),
      .rst_n     (rst_n),
      .trig_i    (trig_common),
      .rearm_i   (cls_rearm[c]),
      .glob_en_i (glob_en_i),
      .any_i     (cls_any[c]),
      .win_i     (cls_win[c]),
      .out_o     (cls_out[c]),
      .code_o    (cls_code[c]),
      .fire_o    (cls_fire[c])
    );
  end

  assign irq_o      = cls_out[CLS_IRQ];
  assign fiq_o      = cls_out[CLS_FIQ];
  assign irq_code_o = cls_code[CLS_IRQ];
  assign fiq_code_o = cls_code[CLS_FIQ];
endmodule

// File: rtl/sorter_chk.sv
module sorter_chk #(
  parameter int unsigned NUM_LINES = 128,
  parameter int unsigned CODE_W    = 7
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_LINES-1:0] pending_i,
  input logic [NUM_LINES-1:0] mask_i,
  input logic [NUM_LINES-1:0] route_fiq_i,
  input logic                 glob_en_i,
  input logic                 rearm_irq_i,
  input logic                 rearm_fiq_i,
  input logic                 irq_o,
  input logic                 fiq_o,
  input logic [CODE_W-1:0]    irq_code_o,
  input logic [CODE_W-1:0]    fiq_code_o,
  input logic [1:0]           cls_fire
);
  AST_IRQ_NEEDS_CAND: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(|(pending_i & ~mask_i & ~route_fiq_i))); // R1
  AST_FIQ_NEEDS_CAND: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fiq_o) |-> $past(|(pending_i & ~mask_i & route_fiq_i))); // R2
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(glob_en_i)); // R6
  AST_FIQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fiq_o) |-> $past(glob_en_i)); // R6
  AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o && !rearm_irq_i |=> irq_o); // R6
  AST_FIQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_o && !rearm_fiq_i |=> fiq_o); // R6
  AST_IRQ_REARM_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    rearm_irq_i && !cls_fire[0] |=> !irq_o); // R7
  AST_FIQ_REARM_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    rearm_fiq_i && !cls_fire[1] |=> !fiq_o); // R7
  AST_IRQ_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cls_fire[0] |=> $stable(irq_code_o)); // R8
  AST_FIQ_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cls_fire[1] |=> $stable(fiq_code_o)); // R8
endmodule

bind intc_prio_sorter sorter_chk #(
  .NUM_LINES (NUM_LINES),
  .CODE_W    (CODE_W)
) u_sorter_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pending_i   (pending_i),
  .mask_i      (mask_i),
  .route_fiq_i (route_fiq_i),
  .glob_en_i   (glob_en_i),
  .rearm_irq_i (rearm_irq_i),
  .rearm_fiq_i (rearm_fiq_i),
  .irq_o       (irq_o),
  .fiq_o       (fiq_o),
  .irq_code_o  (irq_code_o),
  .fiq_code_o  (fiq_code_o),
  .cls_fire    (cls_fire)
);

// File: tb/test_intc_prio_sorter.sv
`timescale 1ns/1ps
module test_intc_prio_sorter;
  localparam int NB = 4;
  localparam int PW = 5;
  localparam int NL = NB * 32;
  localparam int CW = $clog2(NL);

  typedef struct {
    string         req;
    bit            irq;
    bit [CW-1:0]   icode;
    bit            fiq;
    bit [CW-1:0]   fcode;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NL-1:0]    pending = '0;
  logic [NL-1:0]    mask = '1;
  logic [NL-1:0]    route = '0;
  logic [NL*PW-1:0] prio = '0;
  logic glob_en = 1'b0, pend_set = 1'b0, mask_wr = 1'b0, rearm_i = 1'b0, rearm_f = 1'b0;
  logic irq_o, fiq_o;
  logic [CW-1:0] irq_code_o, fiq_code_o;

  int n_chk = 0, n_bad = 0;
  exp_t sb[$];
  bit   m_flag [2] = '{1'b1, 1'b1};
  bit   m_out  [2] = '{1'b0, 1'b0};
  bit [CW-1:0] m_code [2] = '{'0, '0};

  always #10 clk = ~clk;

  intc_prio_sorter #(.NUM_BANKS(NB), .PRIO_W(PW)) i_intc_prio_sorter (
    .clk(clk), .rst_n(rst_n), .pending_i(pending), .mask_i(mask),
    .route_fiq_i(route), .prio_i(prio), .glob_en_i(glob_en),
    .pend_set_i(pend_set), .mask_wr_i(mask_wr), .rearm_irq_i(rearm_i),
    .rearm_fiq_i(rearm_f), .irq_o(irq_o), .fiq_o(fiq_o),
    .irq_code_o(irq_code_o), .fiq_code_o(fiq_code_o));

  task automatic set_prio(int line, int val);
    prio[line*PW +: PW] = PW'(val);
  endtask

  // Reference winner: walk from the top line down, replace only on strictly
  // better priority, so the highest line number among equals is kept.
  task automatic ref_pick(bit fast, output bit found, output bit [CW-1:0] code);
    int best;
    found = 1'b0; code = '0; best = 1 << PW;
    for (int i = NL - 1; i >= 0; i--) begin
      if (pending[i] && !mask[i] && (route[i] == fast)) begin
        if (int'(prio[i*PW +: PW]) < best) begin
          best = int'(prio[i*PW +: PW]);
          code = CW'(i);
          found = 1'b1;
        end
      end
    end
  endtask

  task automatic step(string req, bit ps, bit mw, bit ri, bit rf);
    exp_t e;
    bit fnd; bit [CW-1:0] w;
    @(negedge clk);
    pend_set = ps; mask_wr = mw; rearm_i = ri; rearm_f = rf;
    for (int c = 0; c < 2; c++) begin
      bit re, trig;
      re   = (c == 0) ? ri : rf;
      trig = ps | mw | re;
      ref_pick(c == 1, fnd, w);
      if (trig && (m_flag[c] || re) && fnd && glob_en) begin
        m_code[c] = w; m_flag[c] = 1'b0; m_out[c] = 1'b1;
      end else if (re) begin
        m_flag[c] = 1'b1; m_out[c] = 1'b0;
      end
    end
    e.req = req; e.irq = m_out[0]; e.icode = m_code[0];
    e.fiq = m_out[1]; e.fcode = m_code[1];
    sb.push_back(e);
    @(posedge clk);
    @(negedge clk);
    pend_set = 1'b0; mask_wr = 1'b0; rearm_i = 1'b0; rearm_f = 1'b0;
  endtask

  task automatic cmp(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #5;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      cmp(e.req, "irq_o", int'(irq_o), int'(e.irq));
      cmp(e.req, "irq_code", int'(irq_code_o), int'(e.icode));
      cmp(e.req, "fiq_o", int'(fiq_o), int'(e.fiq));
      cmp(e.req, "fiq_code", int'(fiq_code_o), int'(e.fcode));
    end
  end

  initial begin
    #(20 * 100000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step("R9 reset state", 0, 0, 0, 0);

    // R8: trigger with no candidate (line masked)
    pending[5] = 1'b1; set_prio(5, 3); glob_en = 1'b1;
    step("R8 no candidate", 0, 1, 0, 0);
    // R10: candidate appears without a trigger
    mask = '0;
    step("R10 no trigger", 0, 0, 0, 0);
    // R8: enable off blocks capture
    glob_en = 1'b0;
    step("R8 enable off", 0, 1, 0, 0);
    // R1 R6: capture on mask write
    glob_en = 1'b1;
    step("R1 R6 first capture", 0, 1, 0, 0);
    // R6: flag clear, more urgent line does not replace code
    pending[40] = 1'b1; set_prio(40, 0);
    step("R6 flag clear holds", 1, 0, 0, 0);
    // R3 R5 R7: re-arm picks more urgent line 40 (bank 1, bit 8)
    step("R3 R5 R7 rearm urgent", 0, 0, 1, 0);
    // R4: tie at priority 0 across banks, highest line wins
    pending[100] = 1'b1; pending[2] = 1'b1;
    step("R4 tie high line", 0, 0, 1, 0);
    // R2 R11: fast class capture, normal class untouched
    route[70] = 1'b1; pending[70] = 1'b1; set_prio(70, 7);
    step("R2 R11 fast capture", 1, 0, 0, 0);
    // R1 R11: line 100 moved to fast class; normal re-arm excludes it
    route[100] = 1'b1;
    step("R1 R11 route excludes", 0, 0, 1, 0);
    // R2 R3: fast re-arm picks line 100 (prio 0) over 70 (prio 7)
    step("R2 R3 fast rearm", 0, 0, 0, 1);
    // R7 R8: re-arm with nothing pending drops output, code held
    pending = '0;
    step("R7 R8 irq drop", 0, 0, 1, 0);
    step("R7 R8 fiq drop", 0, 0, 0, 1);
    // R4 R5: tie in last bank
    pending[127] = 1'b1; set_prio(127, 31);
    pending[126] = 1'b1; set_prio(126, 31);
    step("R4 R5 last line", 1, 0, 0, 0);
    // R1: masking the winner, then re-arm picks 126
    mask[127] = 1'b1;
    step("R6 mask write no change", 0, 1, 0, 0);
    step("R1 masked winner", 0, 0, 1, 0);
    // R11: fast re-arm without candidates leaves irq alone
    step("R11 fast rearm idle", 0, 0, 0, 1);
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule